// File: doc/BRIEF.md
# Runtime-Reconfigurable CIC Decimation Filter

This block is the rate-reduction stage at the front of a digital down converter. It takes one signed sample on every clock. A cascade of accumulators runs at the full input rate. A rate selector then keeps one accumulated value out of every R. A cascade of comb stages, each a delay line followed by a subtracter, runs on the kept values. A final stage rounds or truncates the wide result, optionally saturates it, and presents it as a narrower word with a one-clock valid strobe. The datapath uses no multipliers.

The decimation factor and the comb differential delay are live input ports. Either can be changed at any time with no reset or initialisation sequence, and the filter settles to the new response on its own. The number of stages, the data widths, the guard bits, the output scaling shift and the quantisation mode are fixed when the block is elaborated. All internal arithmetic is two's complement with wraparound. Integrator overflow therefore cancels in the combs, provided the internal width covers the full filter gain.

Top module: `cicd_decimator`

## Requirements
- R1: While the synchronous reset is high, `data_o` is 0 and `dv_o` is 0. Reset clears every accumulator, comb delay register and the decimation counter.
- R2: `dv_o` is high for exactly one clock for each decimated word. With constant control inputs, consecutive pulses are exactly R_eff clocks apart, where R_eff is the effective decimation factor.
- R3: R_eff equals `rate_i` for values from 1 to RATE_MAX (default 15). A `rate_i` of 0 is treated as 1, which gives a pulse on every clock.
- R4: Any change of `rate_i` restarts the decimation count on the next clock. No reset is needed, and the output converges to the new steady-state value.
- R5: The effective differential delay M_eff equals `delay_i` for values from 1 to DELAY_MAX (default 2). A value of 0 is treated as 1, and values above DELAY_MAX are treated as DELAY_MAX. A change takes effect without reset.
- R6: For a constant input x held after any change, the settled pre-quantisation result is x·(R_eff·M_eff)^N, where N is the stage count (default 3).
- R7: Quantisation mode encoding: 0 = truncate, 1 = round, 2 = saturate with truncate, 3 = saturate with round. Truncation is floor(v / 2^OUT_SHIFT), with OUT_SHIFT defaulting to 4. Rounding is floor((v + 2^(OUT_SHIFT-1)) / 2^OUT_SHIFT).
- R8: Modes 2 and 3 clamp the scaled value to the range −2^(OUT_W−1) to 2^(OUT_W−1)−1, with OUT_W defaulting to 12. Modes 0 and 1 keep the low OUT_W bits of the scaled value (two's-complement wrap).
- R9: Internal accumulators wrap modulo 2^ACC_W. The settled result of R6 stays exact even after the integrators have wrapped many times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, one input sample per rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| sample_i | input | IN_W | Signed input sample |
| rate_i | input | RATE_W | Decimation factor, 0 is treated as 1 |
| delay_i | input | DLY_W | Comb differential delay, clamped to 1..DELAY_MAX |
| data_o | output | OUT_W | Signed quantised decimated output |
| dv_o | output | 1 | One-clock strobe marking a new output word |

## Verification
The assertions assume that the control inputs reach the block already synchronous to `clk_i`. They also assume that `rate_i` and `delay_i` hold steady between deliberate changes, so that the counter-bound and restart properties compare against a stable effective rate. The stimulus respects this by changing all inputs only on the falling edge, as a single step between sweep points, and then holding them while the filter settles. The sweep covers every rate code, every delay code including the clamped ones, and input values at both extremes of the input range. Four instances, one per quantisation mode, share the same stimulus, so that wrap, clamp, round and truncate behaviour are each compared against arithmetic done in the bench.

// File: rtl/cicd_pkg.sv
package cicd_pkg;

  // Output quantisation behaviour; the encoding is visible at elaboration.
  typedef enum logic [1:0] {
    QM_TRUNC     = 2'd0,
    QM_ROUND     = 2'd1,
    QM_SAT_TRUNC = 2'd2,
    QM_SAT_ROUND = 2'd3
  } qmode_e;

  // Bit growth of an n-stage filter whose largest gain is (rmax*mmax)^n.
  function automatic int growth_bits(input int n, input int rmax, input int mmax);
    return n * $clog2(rmax * mmax);
  endfunction

  function automatic bit mode_rounds(input qmode_e q);
    return (q == QM_ROUND) || (q == QM_SAT_ROUND);
  endfunction

  function automatic bit mode_saturates(input qmode_e q);
    return (q == QM_SAT_TRUNC) || (q == QM_SAT_ROUND);
  endfunction

endpackage

// File: rtl/cicd_rate_sel.sv
module cicd_rate_sel #(
  parameter int RATE_MAX = 15,
  parameter int RATE_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              take_o
);

  logic [RATE_W-1:0] r_eff;
  logic [RATE_W-1:0] r_prev;
  logic [RATE_W-1:0] cnt_q;
  logic              rate_chg;
  logic              wrap_pt;

  // Effective factor: 0 behaves as 1, values above the cap are held at the cap.
  always_comb begin
    if (rate_i == '0)                       r_eff = RATE_W'(1);
    else if (rate_i > RATE_W'(RATE_MAX))    r_eff = RATE_W'(RATE_MAX);
    else                                    r_eff = rate_i;
  end

  assign rate_chg = (r_eff != r_prev);
  assign wrap_pt  = (cnt_q == r_eff - RATE_W'(1));
  assign take_o   = wrap_pt && !rate_chg;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q  <= '0;
      r_prev <= RATE_W'(1);
    end else begin
      r_prev <= r_eff;
      if (rate_chg || wrap_pt) cnt_q <= '0;
      else                     cnt_q <= cnt_q + RATE_W'(1);
    end
  end

  // R2: with a steady rate the phase counter never leaves 0..R_eff-1
  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (rst_i)
    !rate_chg |-> (cnt_q < r_eff));

  // R4: a new rate value restarts the count on the following clock
  a_r4_restart: assert property (@(posedge clk_i) disable iff (rst_i)
    rate_chg |=> (cnt_q == '0));

endmodule

// File: rtl/cicd_integ_chain.sv
module cicd_integ_chain #(
  parameter int IN_W  = 8,
  parameter int ACC_W = 25,
  parameter int NSTG  = 3
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [IN_W-1:0]  sample_i,
  output logic [ACC_W-1:0] acc_o
);

  logic [ACC_W-1:0] acc_q [NSTG];
  logic [ACC_W-1:0] feed  [NSTG];

  assign feed[0] = {{(ACC_W-IN_W){sample_i[IN_W-1]}}, sample_i};

  // Each stage is an accumulator 1/(1-z^-1); sums wrap modulo 2^ACC_W (R9).
  for (genvar k = 0; k < NSTG; k++) begin : g_stage
    if (k > 0) begin : g_link
      assign feed[k] = acc_q[k-1];
    end
    always_ff @(posedge clk_i) begin
      if (rst_i) acc_q[k] <= '0;
      else       acc_q[k] <= acc_q[k] + feed[k];
    end
  end

  assign acc_o = acc_q[NSTG-1];

endmodule

// File: rtl/cicd_comb.sv
module cicd_comb #(
  parameter int ACC_W     = 25,
  parameter int DELAY_MAX = 2,
  parameter int DLY_W     = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             vld_i,
  input  logic [ACC_W-1:0] d_i,
  input  logic [DLY_W-1:0] dly_sel_i,
  output logic             vld_o,
  output logic [ACC_W-1:0] d_o
);

  logic [ACC_W-1:0] line_q [DELAY_MAX];
  logic [ACC_W-1:0] tap;

  // Pick the sample dly_sel_i decimated steps back; the caller keeps it in 1..DELAY_MAX.
  always_comb begin
    tap = line_q[0];
    for (int i = 0; i < DELAY_MAX; i++) begin
      if (dly_sel_i == DLY_W'(i + 1)) tap = line_q[i];
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int i = 0; i < DELAY_MAX; i++) line_q[i] <= '0;
      d_o   <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        line_q[0] <= d_i;
        for (int i = 1; i < DELAY_MAX; i++) line_q[i] <= line_q[i-1];
        d_o <= d_i - tap;
      end
    end
  end

  // R2: each decimated word crosses the stage in exactly one clock
  a_r2_comb_step: assert property (@(posedge clk_i) disable iff (rst_i)
    vld_i |=> vld_o);

  // R2: the stage emits nothing it was not given
  a_r2_comb_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
    !vld_i |=> !vld_o);

  // R6: between decimated words the stage output does not move
  a_r6_comb_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    !vld_i |=> $stable(d_o));

endmodule

// File: rtl/cicd_quant.sv
module cicd_quant #(
  parameter int              ACC_W     = 25,
  parameter int              OUT_W     = 12,
  parameter int              OUT_SHIFT = 4,
  parameter cicd_pkg::qmode_e QMODE    = cicd_pkg::QM_SAT_ROUND
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             vld_i,
  input  logic [ACC_W-1:0] d_i,
  output logic             dv_o,
  output logic [OUT_W-1:0] q_o
);

  localparam int EXT_W = ACC_W + 1;
  localparam logic signed [EXT_W-1:0] HALF =
    cicd_pkg::mode_rounds(QMODE) ? ((EXT_W'(1) << OUT_SHIFT) >> 1) : '0;
  localparam logic signed [EXT_W-1:0] OMAX = EXT_W'((64'sd1 <<< (OUT_W-1)) - 1);
  localparam logic signed [EXT_W-1:0] OMIN = EXT_W'(-(64'sd1 <<< (OUT_W-1)));

  logic signed [EXT_W-1:0] scaled;
  logic        [OUT_W-1:0] q_next;

  // One guard bit keeps the rounding offset from overflowing the wide value.
  function automatic logic signed [EXT_W-1:0] scale(input logic [ACC_W-1:0] v);
    logic signed [EXT_W-1:0] ext;
    ext = $signed({v[ACC_W-1], v});
    return (ext + HALF) >>> OUT_SHIFT;
  endfunction

  assign scaled = scale(d_i);

  always_comb begin
    q_next = scaled[OUT_W-1:0];
    if (cicd_pkg::mode_saturates(QMODE)) begin
      if (scaled > OMAX)      q_next = OMAX[OUT_W-1:0];
      else if (scaled < OMIN) q_next = OMIN[OUT_W-1:0];
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      dv_o <= 1'b0;
      q_o  <= '0;
    end else begin
      dv_o <= vld_i;
      if (vld_i) q_o <= q_next;
    end
  end

  // R2: the strobe lasts one clock per word handed over by the last comb
  a_r2_dv_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
    dv_o |-> $past(vld_i));

  // R1/R2: the output word changes only together with a strobe
  a_r2_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    !dv_o |-> $stable(q_o));

  if (cicd_pkg::mode_saturates(QMODE)) begin : g_sat_chk
    // R8: a value above the output range lands exactly on the positive limit
    a_r8_clamp_hi: assert property (@(posedge clk_i) disable iff (rst_i)
      (vld_i && (scaled > OMAX)) |=> (q_o == OMAX[OUT_W-1:0]));
    // R8: a value below the output range lands exactly on the negative limit
    a_r8_clamp_lo: assert property (@(posedge clk_i) disable iff (rst_i)
      (vld_i && (scaled < OMIN)) |=> (q_o == OMIN[OUT_W-1:0]));
  end

endmodule

// File: rtl/cicd_decimator.sv
module cicd_decimator #(
  parameter int               IN_W      = 8,
  parameter int               OUT_W     = 12,
  parameter int               N_STAGES  = 3,
  parameter int               RATE_MAX  = 15,
  parameter int               RATE_W    = 4,
  parameter int               DELAY_MAX = 2,
  parameter int               DLY_W     = $clog2(DELAY_MAX + 1),
  parameter int               GUARD     = 2,
  parameter int               OUT_SHIFT = 4,
  parameter cicd_pkg::qmode_e QMODE     = cicd_pkg::QM_SAT_ROUND
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [IN_W-1:0]   sample_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [DLY_W-1:0]  delay_i,
  output logic [OUT_W-1:0]  data_o,
  output logic              dv_o
);

  localparam int ACC_W = IN_W + cicd_pkg::growth_bits(N_STAGES, RATE_MAX, DELAY_MAX) + GUARD;

  logic [ACC_W-1:0] integ_out;
  logic             take;
  logic [DLY_W-1:0] m_eff;
  logic [ACC_W-1:0] cd [N_STAGES+1];
  logic             cv [N_STAGES+1];

  // R5: clamp the differential delay into 1..DELAY_MAX
  always_comb begin
    if (delay_i == '0)                       m_eff = DLY_W'(1);
    else if (delay_i > DLY_W'(DELAY_MAX))    m_eff = DLY_W'(DELAY_MAX);
    else                                     m_eff = delay_i;
  end

  cicd_integ_chain #(.IN_W(IN_W), .ACC_W(ACC_W), .NSTG(N_STAGES)) integ_i (
    .clk_i(clk_i), .rst_i(rst_i), .sample_i(sample_i), .acc_o(integ_out)
  );

  cicd_rate_sel #(.RATE_MAX(RATE_MAX), .RATE_W(RATE_W)) rsel_i (
    .clk_i(clk_i), .rst_i(rst_i), .rate_i(rate_i), .take_o(take)
  );

  assign cd[0] = integ_out;
  assign cv[0] = take;

  for (genvar s = 0; s < N_STAGES; s++) begin : g_comb
    cicd_comb #(.ACC_W(ACC_W), .DELAY_MAX(DELAY_MAX), .DLY_W(DLY_W)) comb_i (
      .clk_i(clk_i), .rst_i(rst_i),
      .vld_i(cv[s]), .d_i(cd[s]), .dly_sel_i(m_eff),
      .vld_o(cv[s+1]), .d_o(cd[s+1])
    );
  end

  cicd_quant #(.ACC_W(ACC_W), .OUT_W(OUT_W), .OUT_SHIFT(OUT_SHIFT), .QMODE(QMODE)) quant_i (
    .clk_i(clk_i), .rst_i(rst_i), .vld_i(cv[N_STAGES]), .d_i(cd[N_STAGES]),
    .dv_o(dv_o), .q_o(data_o)
  );

  // R5: the effective delay seen by the combs is always a legal tap
  a_r5_delay_legal: assert property (@(posedge clk_i) disable iff (rst_i)
    (m_eff != '0) && (m_eff <= DLY_W'(DELAY_MAX)));

  // R1: nothing is announced in the first clock after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk_i)
    $fell(rst_i) |-> !dv_o);

endmodule

// File: tb/cicd_decimator_tb.sv
module cicd_decimator_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int IN_W  = 8;
  localparam int OUT_W = 12;
  localparam int SHIFT = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [IN_W-1:0] sample = '0;
  logic [3:0]      rate = 4'd1;
  logic [1:0]      dly = 2'd1;
  logic [OUT_W-1:0] q_w [4];
  logic             dv_w [4];

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // One instance per quantisation mode, all driven by the same stimulus.
  for (genvar g = 0; g < 4; g++) begin : g_mode
    cicd_decimator #(.QMODE(cicd_pkg::qmode_e'(g))) dut_i (
      .clk_i(clk), .rst_i(rst), .sample_i(sample), .rate_i(rate), .delay_i(dly),
      .data_o(q_w[g]), .dv_o(dv_w[g])
    );
  end

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint fdiv(input longint a, input longint b);
    if (a >= 0) return a / b;
    return -((-a + b - 1) / b);
  endfunction

  // Expected output of one mode, from R7 and R8.
  function automatic longint model(input int mode, input longint y);
    longint v, lim_hi, lim_lo, span;
    lim_hi = (64'sd1 <<< (OUT_W-1)) - 1;
    lim_lo = -(64'sd1 <<< (OUT_W-1));
    span   = 64'sd1 <<< OUT_W;
    v = (mode == 1 || mode == 3) ? fdiv(y + (1 <<< (SHIFT-1)), 1 <<< SHIFT)
                                 : fdiv(y, 1 <<< SHIFT);
    if (mode >= 2) begin
      if (v > lim_hi) v = lim_hi;
      if (v < lim_lo) v = lim_lo;
    end else begin
      v = ((v % span) + span) % span;
      if (v > lim_hi) v = v - span;
    end
    return v;
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    longint xs [4] = '{127, -128, -1, 45};
    // R1: outputs held at zero during reset
    repeat (4) @(negedge clk);
    for (int g = 0; g < 4; g++) begin
      chk("R1 data", longint'(q_w[g]), 0);
      chk("R1 dv", longint'(dv_w[g]), 0);
    end
    rst = 1'b0;

    // Every step changes rate or delay or sample with no reset (R4, R5);
    // integrators wrap repeatedly during the sweep (R9).
    for (int r = 0; r < 16; r++) begin
      for (int m = 0; m < 4; m++) begin
        for (int xi = 0; xi < 4; xi++) begin
          int re, me, dv_cnt, cyc, last;
          longint x, gain, y;
          string tag;
          re = (r == 0) ? 1 : r;
          me = (m == 0) ? 1 : ((m > 2) ? 2 : m);
          x  = xs[xi];
          gain = longint'(re * me);
          y = x * gain * gain * gain;
          @(negedge clk);
          rate = 4'(r);
          dly = 2'(m);
          sample = IN_W'(x);
          dv_cnt = 0; cyc = 0; last = 0;
          while (dv_cnt < 15) begin
            @(negedge clk);
            cyc++;
            if (dv_w[0]) begin
              dv_cnt++;
              if (dv_cnt == 14) last = cyc;
              if (dv_cnt == 15) begin
                tag = (r == 0) ? "R3 rate0 gap" : "R2 gap";
                chk(tag, longint'(cyc - last), longint'(re));
                for (int g = 0; g < 4; g++) begin
                  tag = $sformatf("%s R6 R9 R4 R5 mode%0d r=%0d m=%0d x=%0d",
                                  (g >= 2) ? "R8" : "R7", g, r, m, x);
                  chk(tag, longint'($signed(q_w[g])), model(g, y));
                end
              end
            end
          end
        end
      end
    end
    summary();
    $finish;
  end

endmodule